// File: doc/BRIEF.md
# Signed Four-Function Arithmetic Unit

This block computes the sum, difference, product or quotient of two 32-bit two's-complement operands. A two-bit operation code picks the function. The caller raises `start` for one cycle while the unit is idle. The unit captures the operands and the operation code on that edge, so the ports may change right afterwards. Completion is signalled by a one-cycle `done` pulse. In that same cycle `result` and `err` carry the outcome, and both hold their values until the next completion.

When the mathematically exact answer does not fit in 32 signed bits, `err` goes high and `result` reads zero. This covers add and subtract overflow, products outside the range, division by zero, and the one quotient that overflows: the most negative value divided by minus one.

Addition, subtraction and multiplication finish in a single working cycle. Division runs a restoring shift-subtract loop over operand magnitudes, one quotient bit per cycle, and then corrects the sign. The quotient therefore rounds toward zero.

Top module: `sarith_core`

## Requirements
- R1: The operation code `op_sel` selects the function: 2'b00 gives opa+opb, 2'b01 gives opa-opb, 2'b10 gives opa*opb and 2'b11 gives opa/opb. All values are 32-bit two's complement, and a representable answer appears on `result` with `err` low.
- R2: An addition whose exact sum lies outside [-2^31, 2^31-1] sets `err`.
- R3: A subtraction whose exact difference lies outside [-2^31, 2^31-1] sets `err`.
- R4: A multiplication whose full signed product lies outside [-2^31, 2^31-1] sets `err`, for every sign combination.
- R5: Division truncates toward zero. The quotient is negative exactly when the operand signs differ and the quotient magnitude is non-zero.
- R6: Division by zero sets `err`.
- R7: Dividing -2^31 by -1 sets `err`. Dividing -2^31 by 1 gives -2^31 without error.
- R8: Whenever `err` is high, `result` is zero.
- R9: For add, subtract and multiply, `done` is high for the cycle that starts at the first rising edge after the edge that accepted `start`.
- R10: For divide, `done` is high for the cycle that starts at the 33rd rising edge after the edge that accepted `start`, which is DATA_W+1 edges.
- R11: A `start` that arrives while an operation is in progress is ignored. It neither shortens nor adds a completion, and it does not alter the pending result.
- R12: While `rst_n` is low, `done`, `err` and `result` are zero and the unit is idle, including when reset interrupts a division.
- R13: `done` lasts exactly one cycle. `result` and `err` change only in a cycle where `done` is high, and they hold afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches an operation when the unit is idle |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 multiply, 11 divide |
| opa | input | DATA_W (32) | First operand (minuend, multiplicand or dividend) |
| opb | input | DATA_W (32) | Second operand (addend, subtrahend, multiplier or divisor) |
| result | output | DATA_W (32) | Outcome of the last completed operation, zero on error |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result not representable, valid with `done` |

## Verification
The bench aims at the range edges: sums and differences one step past 2^31-1 or -2^31, and products such as 65536 x -32768 that land exactly on -2^31 next to their overflowing twins. A unit that tested overflow on the unsigned carry, or only on the low product bits, would miss these or flag the wrong ones. Division cases mix every sign pairing with dividends smaller than the divisor, -2^31 by 1, by -1 and by 0. A divider that rounded toward minus infinity would return -2 for -5/3, and one that trusted the magnitude bit alone would either wrap -2^31/-1 silently or flag -2^31/1. Finally, a start during a division and a reset in mid-division catch a unit that restarts, emits a second `done`, or keeps a stale result.

// File: rtl/sarith_pkg.sv
package sarith_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_FAST = 2'b01,
    ST_DIV  = 2'b10
  } state_e;

endpackage

// File: rtl/sarith_rst_sync.sv
module sarith_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= '0;
    end else begin
      ff_q <= {ff_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = ff_q[STAGES-1];

endmodule

// File: rtl/sarith_addsub.sv
module sarith_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic [W-1:0] cin;

  assign b_eff = sub ? ~b : b;
  assign cin   = {{(W-1){1'b0}}, sub};
  assign sum   = a + b_eff + cin;
  // like-signed inputs giving an opposite-signed output cannot be exact
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/sarith_mul.sv
module sarith_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod,
  output logic         ovf
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] full;
  logic [W:0]           upper;

  assign full  = $signed(a) * $signed(b);
  assign prod  = full[W-1:0];
  // the product fits only if its top W+1 bits are a pure sign extension
  assign upper = full[PW-1:W-1];
  assign ovf   = !((&upper) || !(|upper));

endmodule

// File: rtl/sarith_div.sv
module sarith_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic         err,
  output logic         fin
);

  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic          neg_q, neg_d;
  logic          zero_q, zero_d;
  logic          run_q, run_d;
  logic          fin_q, fin_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic [W-1:0]  a_mag;
  logic [W-1:0]  b_mag;
  logic          upd;

  assign a_mag   = dividend[W-1] ? (~dividend + W'(1)) : dividend;
  assign b_mag   = divisor[W-1]  ? (~divisor + W'(1))  : divisor;
  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign upd     = load || run_q;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    neg_d  = neg_q;
    zero_d = zero_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    fin_d  = 1'b0;
    if (load) begin
      rem_d  = '0;
      quo_d  = a_mag;
      dvs_d  = b_mag;
      neg_d  = dividend[W-1] ^ divisor[W-1];
      zero_d = (divisor == '0);
      run_d  = 1'b1;
      cnt_d  = '0;
    end else if (run_q) begin
      quo_d = {quo_q[W-2:0], ~trial[W]};
      rem_d = trial[W] ? shifted[W-1:0] : trial[W-1:0];
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(W - 1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= fin_d;
      if (upd) begin
        rem_q  <= rem_d;
        quo_q  <= quo_d;
        dvs_q  <= dvs_d;
        neg_q  <= neg_d;
        zero_q <= zero_d;
        run_q  <= run_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  // sign correction on the unsigned magnitude quotient
  assign quo = neg_q ? (~quo_q + W'(1)) : quo_q;
  // a positive quotient with its top bit set is 2^(W-1): not representable
  assign err = zero_q || (!neg_q && quo_q[W-1]);
  assign fin = fin_q;

endmodule

// File: rtl/sarith_core.sv
module sarith_core
  import sarith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              err
);

  logic              rst_i_n;
  state_e            state_q, state_d;
  op_e               op_q, op_in;
  logic [DATA_W-1:0] a_q, b_q;
  logic [DATA_W-1:0] res_q;
  logic              err_q, done_q;

  logic              idle;
  logic              accept;
  logic              div_load;
  logic              cap_en;
  logic [DATA_W-1:0] cap_val;
  logic              cap_err;

  logic [DATA_W-1:0] as_sum;
  logic              as_ovf;
  logic [DATA_W-1:0] mul_p;
  logic              mul_ovf;
  logic [DATA_W-1:0] div_q;
  logic              div_err;
  logic              div_fin;

  sarith_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sarith_addsub #(.W(DATA_W)) u_addsub (
    .a   (a_q),
    .b   (b_q),
    .sub (op_q == OP_SUB),
    .sum (as_sum),
    .ovf (as_ovf)
  );

  sarith_mul #(.W(DATA_W)) u_mul (
    .a    (a_q),
    .b    (b_q),
    .prod (mul_p),
    .ovf  (mul_ovf)
  );

  sarith_div #(.W(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (div_load),
    .dividend (opa),
    .divisor  (opb),
    .quo      (div_q),
    .err      (div_err),
    .fin      (div_fin)
  );

  assign op_in    = op_e'(op_sel);
  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && start;
  assign div_load = accept && (op_in == OP_DIV);
  assign cap_en   = (state_q == ST_FAST) || ((state_q == ST_DIV) && div_fin);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = (op_in == OP_DIV) ? ST_DIV : ST_FAST;
      ST_FAST: state_d = ST_IDLE;
      ST_DIV:  if (div_fin) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // outcome select
  always_comb begin
    unique case (op_q)
      OP_ADD, OP_SUB: begin
        cap_val = as_sum;
        cap_err = as_ovf;
      end
      OP_MUL: begin
        cap_val = mul_p;
        cap_err = mul_ovf;
      end
      default: begin
        cap_val = div_q;
        cap_err = div_err;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADD;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= cap_en;
      if (accept) begin
        op_q <= op_in;
        a_q  <= opa;
        b_q  <= opb;
      end
      if (cap_en) begin
        res_q <= cap_err ? '0 : cap_val;
        err_q <= cap_err;
      end
    end
  end

  assign result = res_q;
  assign done   = done_q;
  assign err    = err_q;

endmodule

// File: rtl/sarith_chk.sv
module sarith_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op_sel,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] result,
  input logic              done,
  input logic              err,
  input logic              idle
);

  logic [DATA_W-1:0] sum_w;
  assign sum_w = opa + opb;

  // R13: completion pulse lasts one cycle
  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13: outputs change only together with done
  assert_result_moves_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  assert_err_moves_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R8: error forces a zero result
  assert_err_zero_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (result == '0));

  // R9: single-cycle functions complete one edge after acceptance
  assert_fast_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && (op_sel != 2'b11)) |=> (!done ##1 done));

  // R2: an overflowing addition is flagged on completion
  assert_add_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && (op_sel == 2'b00) && (opa[DATA_W-1] == opb[DATA_W-1])
     && (sum_w[DATA_W-1] != opa[DATA_W-1])) |-> ##2 (done && err));

endmodule

bind sarith_core sarith_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_i_n),
  .start  (start),
  .op_sel (op_sel),
  .opa    (opa),
  .opb    (opb),
  .result (result),
  .done   (done),
  .err    (err),
  .idle   (idle)
);

// File: tb/sarith_core_test.sv
module sarith_core_test;

  localparam int W = 32;
  localparam logic [1:0] C_ADD = 2'b00;
  localparam logic [1:0] C_SUB = 2'b01;
  localparam logic [1:0] C_MUL = 2'b10;
  localparam logic [1:0] C_DIV = 2'b11;
  localparam logic [W-1:0] MINV = 32'h8000_0000;

  typedef struct packed {
    logic [1:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] q;
    logic         e;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{C_ADD, 32'sd7, 32'sd3, 32'sd10, 1'b0},
    '{C_ADD, -32'sd7, -32'sd1, -32'sd8, 1'b0},
    '{C_ADD, 32'sd2147483647, -32'sd1, 32'sd2147483646, 1'b0},
    '{C_ADD, 32'sd2147483647, 32'sd1, 32'sd0, 1'b1},
    '{C_ADD, -32'sd2147483645, -32'sd100, 32'sd0, 1'b1},
    '{C_ADD, MINV, 32'sd2147483647, -32'sd1, 1'b0},
    '{C_SUB, -32'sd7, 32'sd1, -32'sd8, 1'b0},
    '{C_SUB, 32'sd7, -32'sd1, 32'sd8, 1'b0},
    '{C_SUB, -32'sd2147483645, 32'sd1000, 32'sd0, 1'b1},
    '{C_SUB, 32'sd2147483645, -32'sd1000, 32'sd0, 1'b1},
    '{C_SUB, -32'sd1000, 32'sd2147483645, 32'sd0, 1'b1},
    '{C_SUB, 32'sd1000, -32'sd2147483645, 32'sd0, 1'b1},
    '{C_SUB, 32'sd0, MINV, 32'sd0, 1'b1},
    '{C_MUL, -32'sd3, 32'sd2, -32'sd6, 1'b0},
    '{C_MUL, -32'sd3, -32'sd2, 32'sd6, 1'b0},
    '{C_MUL, 32'sd268435456, -32'sd2, -32'sd536870912, 1'b0},
    '{C_MUL, 32'sd268435456, 32'sd32, 32'sd0, 1'b1},
    '{C_MUL, 32'sd90000, 32'sd100000, 32'sd0, 1'b1},
    '{C_MUL, 32'sd90000, -32'sd100000, 32'sd0, 1'b1},
    '{C_MUL, -32'sd90000, 32'sd100000, 32'sd0, 1'b1},
    '{C_MUL, -32'sd90000, -32'sd100000, 32'sd0, 1'b1},
    '{C_MUL, MINV, 32'sd1, MINV, 1'b0},
    '{C_MUL, MINV, -32'sd1, 32'sd0, 1'b1},
    '{C_MUL, 32'sd65536, -32'sd32768, MINV, 1'b0},
    '{C_MUL, 32'sd65536, 32'sd32768, 32'sd0, 1'b1},
    '{C_DIV, -32'sd5, 32'sd3, -32'sd1, 1'b0},
    '{C_DIV, 32'sd100, 32'sd51, 32'sd1, 1'b0},
    '{C_DIV, 32'sd100, 32'sd49, 32'sd2, 1'b0},
    '{C_DIV, 32'sd153156, -32'sd3543, -32'sd43, 1'b0},
    '{C_DIV, -32'sd153156, -32'sd3543, 32'sd43, 1'b0},
    '{C_DIV, -32'sd153156, 32'sd3543, -32'sd43, 1'b0},
    '{C_DIV, 32'sd7, 32'sd3, 32'sd2, 1'b0},
    '{C_DIV, 32'sd0, -32'sd9, 32'sd0, 1'b0},
    '{C_DIV, 32'sd3, -32'sd7, 32'sd0, 1'b0},
    '{C_DIV, MINV, 32'sd1, MINV, 1'b0},
    '{C_DIV, 32'sd2147483647, -32'sd1, -32'sd2147483647, 1'b0},
    '{C_DIV, MINV, 32'sd2147483647, -32'sd1, 1'b0},
    '{C_DIV, MINV, -32'sd1, 32'sd0, 1'b1},
    '{C_DIV, MINV, 32'sd0, 32'sd0, 1'b1},
    '{C_DIV, 32'sd5, 32'sd0, 32'sd0, 1'b1}
  };

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [1:0]   op_sel;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [W-1:0] result;
  logic         done;
  logic         err;

  int n_chk;
  int n_fail;

  sarith_core #(.DATA_W(W)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_sel (op_sel),
    .opa    (opa),
    .opb    (opb),
    .result (result),
    .done   (done),
    .err    (err)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(vec_t v);
    if (!v.e) return (v.op == C_DIV) ? "R5" : "R1";
    case (v.op)
      C_ADD:   return "R2";
      C_SUB:   return "R3";
      C_MUL:   return "R4";
      default: return (v.b == '0) ? "R6" : "R7";
    endcase
  endfunction

  // lat counts falling edges after the one where start was driven
  task automatic do_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] r, output logic e, output int lat,
                       output bit single, output bit held);
    @(negedge clk);
    op_sel = op; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; opa = ~a; opb = a ^ b; op_sel = ~op;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    r = result;
    e = err;
    @(negedge clk);
    single = !done;
    held   = (result == r) && (err == e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog expired: actual 150000 cycles expected fewer");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    vec_t         v;
    logic [W-1:0] r;
    logic         e;
    int           lat;
    bit           single;
    bit           held;
    string        tag;
    int           first;
    int           ndone;
    logic [W-1:0] seen;

    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; op_sel = 2'b00; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R12", "done in reset", longint'(done), 0);
    check(err == 1'b0, "R12", "err in reset", longint'(err), 0);
    check(result == '0, "R12", "result in reset", longint'($signed(result)), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R12", "done after release", longint'(done), 0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      do_op(v.op, v.a, v.b, r, e, lat, single, held);
      tag = req_of(v);
      check(e == v.e, tag, $sformatf("vector %0d err", i), longint'(e), longint'(v.e));
      check(r == v.q, v.e ? "R8" : tag, $sformatf("vector %0d result", i),
            longint'($signed(r)), longint'($signed(v.q)));
      check(lat == ((v.op == C_DIV) ? W + 2 : 2), (v.op == C_DIV) ? "R10" : "R9",
            $sformatf("vector %0d latency", i), longint'(lat),
            longint'((v.op == C_DIV) ? W + 2 : 2));
      check(single, "R13", $sformatf("vector %0d done width", i), longint'(single), 1);
      check(held, "R13", $sformatf("vector %0d hold", i), longint'(held), 1);
    end

    // R11: start during a division is ignored
    @(negedge clk);
    op_sel = C_DIV; opa = 32'sd100; opb = 32'sd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first = 0; ndone = 0; seen = '0;
    for (int c = 2; c <= W + 6; c++) begin
      if (c == 10) begin op_sel = C_ADD; opa = 32'sd1; opb = 32'sd1; start = 1'b1; end
      if (c == 11) start = 1'b0;
      @(negedge clk);
      if (done) begin
        ndone++;
        if (first == 0) first = c;
        seen = result;
      end
    end
    check(ndone == 1, "R11", "completions", longint'(ndone), 1);
    check(first == W + 2, "R11", "completion cycle", longint'(first), longint'(W + 2));
    check(seen == 32'sd14, "R11", "quotient", longint'($signed(seen)), 14);

    // R12: reset in the middle of a division
    @(negedge clk);
    op_sel = C_DIV; opa = -32'sd1000; opb = 32'sd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R12", "done after mid reset", longint'(done), 0);
    check(result == '0, "R12", "result after mid reset", longint'($signed(result)), 0);
    check(err == 1'b0, "R12", "err after mid reset", longint'(err), 0);
    repeat (W + 4) @(negedge clk);
    check(done == 1'b0, "R12", "no completion in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_op(C_SUB, 32'sd2, 32'sd5, r, e, lat, single, held);
    check(r == -32'sd3, "R1", "sub after reset", longint'($signed(r)), -3);
    check(lat == 2, "R9", "latency after reset", longint'(lat), 2);

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

endmodule